// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen visible 32-bit registers of a small processor whose program counter lives in a 26-bit, word-aligned address field. Some of the visible registers are backed by different physical storage depending on the processor mode. There are four modes: User, FIQ, IRQ and Supervisor. In FIQ mode, indices 8 to 14 select seven private registers. IRQ and Supervisor each have a private pair for indices 13 and 14. Every other index selects the shared user copy.

The core reads two registers per cycle through combinational ports and writes one per clock. It changes mode through a mode-select input. It raises an exception-entry request, which switches the mode and places a return address in the link register (index 14) of the new mode. Two further combinational outputs give the program counter plus a caller-chosen offset. One output has the status bits supplied by the core merged in, and the other has those bits cleared.

Top module: `banked_regfile`

## Requirements
- R1: There are sixteen visible registers, indexed 0 to 15. Index 15 is the program counter. A write to index 15 stores the data masked to the address field: bits [1:0] and bits [31:26] are cleared. Reading index 15 returns the stored program counter.
- R2: Mode encoding is User=0, FIQ=1, IRQ=2, Supervisor=3. In FIQ mode, indices 8 to 14 reach seven registers that no other mode can see. Indices 0 to 7 reach the same storage in every mode.
- R3: In IRQ mode and in Supervisor mode, indices 13 and 14 reach a private pair owned by that mode. Indices 0 to 12 reach the User copies.
- R4: After reset (synchronous, rst_n low), the mode is Supervisor (3) and every register, including the program counter, reads zero.
- R5: An exception with kind 0 (IRQ) sets the mode to IRQ. It also writes ((PC + 8) masked to the address field) into index 14 of IRQ mode.
- R6: An exception with kind 1 (FIQ) sets the mode to FIQ. It also writes ((PC + 8) masked) into index 14 of FIQ mode.
- R7: An exception with kind 2 or 3 sets the mode to Supervisor. It also writes ((PC + 4) masked) into index 14 of Supervisor mode.
- R8: pc_stat_data equals ((PC + pc_offset) masked to the address field) bitwise-ORed with status_in.
- R9: pc_only_data equals (PC + pc_offset) masked to the address field, with no status bits.
- R10: A mode-select request takes effect at the next clock edge. Reads and writes in the same cycle use the old mapping.
- R11: If an exception-entry request and a normal write target the same physical register in one cycle, the exception's return address is stored. An exception-entry request also takes priority over a mode-select request in the same cycle.
- R12: Values written in one mode are still present after the block has passed through all the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| mode_set_en | input | 1 | Request a mode change |
| mode_set_val | input | 2 | Requested mode (0 User, 1 FIQ, 2 IRQ, 3 Supervisor) |
| exc_en | input | 1 | Exception-entry request |
| exc_kind | input | 2 | 0 IRQ, 1 FIQ, 2 or 3 Supervisor |
| status_in | input | 32 | Status bits to merge into the combined read |
| pc_offset | input | 32 | Offset added to the program counter for the PC reads |
| pc_stat_data | output | 32 | Offset PC, masked, ORed with status_in |
| pc_only_data | output | 32 | Offset PC, masked, status cleared |
| mode_out | output | 2 | Current mode |

## Verification
The bench builds the block with its default parameters: 32-bit data and a 26-bit address field. With these values, masking the top six bits and the low two bits can be seen directly, and an offset that carries out of the address field wraps to a small value. The default bank layout gives 26 physical registers. This lets the bench place one distinct value in each of User, FIQ, IRQ and Supervisor storage and read each back after visiting the other modes. The same-cycle interactions between a mode change and a read, and between an exception and a write, are driven directly at these default widths.

// File: rtl/banked_regfile_pkg.sv
// Package: shared mode type and bank layout constants for the banked register file.
// Assumes sixteen visible indices with the top index reserved for the PC.
package banked_regfile_pkg;

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_FIQ = 2'd1,
        MODE_IRQ = 2'd2,
        MODE_SVC = 2'd3
    } bank_mode_e;

    localparam int NUM_VIS   = 16;
    localparam int IDX_W     = $clog2(NUM_VIS);
    localparam int PC_IDX    = NUM_VIS - 1;
    localparam int LINK_IDX  = PC_IDX - 1;
    localparam int FIQ_LO    = 8;
    localparam int PRIV_LO   = 13;
    localparam int NUM_USR   = PC_IDX;
    localparam int FIQ_CNT   = PC_IDX - FIQ_LO;
    localparam int PRIV_CNT  = PC_IDX - PRIV_LO;
    localparam int FIQ_BASE  = NUM_USR;
    localparam int IRQ_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int SVC_BASE  = IRQ_BASE + PRIV_CNT;
    localparam int NUM_PHYS  = SVC_BASE + PRIV_CNT;
    localparam int SLOT_W    = $clog2(NUM_PHYS);

endpackage

// File: rtl/banked_regfile_map.sv
// Module: maps a visible register index plus a mode onto a physical slot.
// Assumes the index is below the PC index; the PC index yields a don't-care slot.
module banked_regfile_map
    import banked_regfile_pkg::*;
(
    input  bank_mode_e              mode,
    input  logic [IDX_W-1:0]        idx,
    output logic [SLOT_W-1:0]       slot
);

    // Pick the private bank when the mode owns the index, else the user copy.
    always_comb begin
        slot = SLOT_W'(idx);
        if (mode == MODE_FIQ && int'(idx) >= FIQ_LO && int'(idx) < PC_IDX)
            slot = SLOT_W'(FIQ_BASE + int'(idx) - FIQ_LO);
        else if (mode == MODE_IRQ && int'(idx) >= PRIV_LO && int'(idx) < PC_IDX)
            slot = SLOT_W'(IRQ_BASE + int'(idx) - PRIV_LO);
        else if (mode == MODE_SVC && int'(idx) >= PRIV_LO && int'(idx) < PC_IDX)
            slot = SLOT_W'(SVC_BASE + int'(idx) - PRIV_LO);
    end

endmodule

// File: rtl/banked_regfile_mode.sv
// Module: current-mode register with exception-entry priority.
// Assumes exception entry outranks a same-cycle mode-select request.
module banked_regfile_mode
    import banked_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_set_en,
    input  logic [1:0]  mode_set_val,
    input  logic        exc_en,
    input  logic [1:0]  exc_kind,
    output bank_mode_e  mode_q,
    output bank_mode_e  exc_mode
);

    // Decode the mode an exception of the given kind enters.
    always_comb begin
        case (exc_kind)
            2'd0:    exc_mode = MODE_IRQ;
            2'd1:    exc_mode = MODE_FIQ;
            default: exc_mode = MODE_SVC;
        endcase
    end

    // Hold the mode; exception first, then an explicit request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_SVC;
        else if (exc_en)
            mode_q <= exc_mode;
        else if (mode_set_en)
            mode_q <= bank_mode_e'(mode_set_val);
    end

    // R5 R6 R7 R11
    exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> (mode_q == ($past(exc_kind) == 2'd0 ? MODE_IRQ :
                               $past(exc_kind) == 2'd1 ? MODE_FIQ : MODE_SVC)));

    // R10
    mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set_en && !exc_en) |=> (mode_q == bank_mode_e'($past(mode_set_val))));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_set_en && !exc_en) |=> $stable(mode_q));

endmodule

// File: rtl/banked_regfile_pcfmt.sv
// Module: forms the offset program counter, with and without status bits.
// Assumes the stored PC is already confined to the address field.
module banked_regfile_pcfmt #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic [DATA_W-1:0] pc_q,
    input  logic [DATA_W-1:0] pc_offset,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] pc_stat_data,
    output logic [DATA_W-1:0] pc_only_data
);

    localparam logic [DATA_W-1:0] ADDR_MASK =
        ((DATA_W'(1) << ADDR_W) - DATA_W'(1)) & ~DATA_W'(3);

    // Add the offset, clip to the address field, then merge status.
    always_comb begin
        pc_only_data = (pc_q + pc_offset) & ADDR_MASK;
        pc_stat_data = pc_only_data | status_in;
    end

endmodule

// File: rtl/banked_regfile.sv
// Module: sixteen-register file with mode-dependent banking, PC masking and
// exception-entry link writes. Assumes one write per cycle and combinational reads.
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_set_en,
    input  logic [1:0]        mode_set_val,
    input  logic              exc_en,
    input  logic [1:0]        exc_kind,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] pc_offset,
    output logic [DATA_W-1:0] pc_stat_data,
    output logic [DATA_W-1:0] pc_only_data,
    output logic [1:0]        mode_out
);

    localparam logic [DATA_W-1:0] ADDR_MASK =
        ((DATA_W'(1) << ADDR_W) - DATA_W'(1)) & ~DATA_W'(3);
    localparam int NUM_MAP = 4;   // read A, read B, write, exception link

    bank_mode_e        mode_q;
    bank_mode_e        exc_mode;
    logic [DATA_W-1:0] bank_q [NUM_PHYS];
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] ret_addr;
    logic [IDX_W-1:0]  map_idx  [NUM_MAP];
    bank_mode_e        map_mode [NUM_MAP];
    logic [SLOT_W-1:0] map_slot [NUM_MAP];

    banked_regfile_mode u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_set_en  (mode_set_en),
        .mode_set_val (mode_set_val),
        .exc_en       (exc_en),
        .exc_kind     (exc_kind),
        .mode_q       (mode_q),
        .exc_mode     (exc_mode)
    );

    // Route each access's index and mode to its mapper.
    always_comb begin
        map_idx[0]  = rd_a_idx;  map_mode[0] = mode_q;
        map_idx[1]  = rd_b_idx;  map_mode[1] = mode_q;
        map_idx[2]  = wr_idx;    map_mode[2] = mode_q;
        map_idx[3]  = IDX_W'(LINK_IDX);
        map_mode[3] = exc_mode;
    end

    for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
        banked_regfile_map u_map (
            .mode (map_mode[g]),
            .idx  (map_idx[g]),
            .slot (map_slot[g])
        );
    end

    // Return address: +8 for interrupt kinds, +4 for supervisor entry.
    always_comb begin
        ret_addr = (pc_q + ((exc_kind[1] == 1'b0) ? DATA_W'(8) : DATA_W'(4))) & ADDR_MASK;
    end

    // Update storage; the exception link write is last so it wins a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) bank_q[i] <= '0;
            pc_q <= '0;
        end else begin
            if (wr_en && int'(wr_idx) == PC_IDX)
                pc_q <= wr_data & ADDR_MASK;
            else if (wr_en)
                bank_q[map_slot[2]] <= wr_data;
            if (exc_en)
                bank_q[map_slot[3]] <= ret_addr;
        end
    end

    // Serve the two read ports, PC index bypassing the banks.
    always_comb begin
        rd_a_data = (int'(rd_a_idx) == PC_IDX) ? pc_q : bank_q[map_slot[0]];
        rd_b_data = (int'(rd_b_idx) == PC_IDX) ? pc_q : bank_q[map_slot[1]];
        mode_out  = mode_q;
    end

    banked_regfile_pcfmt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pcfmt (
        .pc_q         (pc_q),
        .pc_offset    (pc_offset),
        .status_in    (status_in),
        .pc_stat_data (pc_stat_data),
        .pc_only_data (pc_only_data)
    );

    // R1
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) == PC_IDX) |=> (pc_q == ($past(wr_data) & ADDR_MASK)));

    // R1
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && int'(wr_idx) == PC_IDX) |=> $stable(pc_q));

    // R5 R6 R7
    link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> (bank_q[$past(map_slot[3])] == $past(ret_addr)));

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, mode_set_en = 1'b0, exc_en = 1'b0;
    logic [1:0]  mode_set_val = '0, exc_kind = '0, mode_out;
    logic [31:0] status_in = '0, pc_offset = '0, pc_stat_data, pc_only_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mode_set_en(mode_set_en), .mode_set_val(mode_set_val),
        .exc_en(exc_en), .exc_kind(exc_kind),
        .status_in(status_in), .pc_offset(pc_offset),
        .pc_stat_data(pc_stat_data), .pc_only_data(pc_only_data),
        .mode_out(mode_out)
    );

    // Entries: {mode, index, data}; each targets a distinct physical register.
    localparam logic [37:0] WR_TAB [8] = '{
        {2'd0, 4'd3,  32'h1111_0003},
        {2'd0, 4'd9,  32'h1111_0009},
        {2'd0, 4'd13, 32'h1111_000D},
        {2'd1, 4'd9,  32'h2222_0009},
        {2'd1, 4'd13, 32'h2222_000D},
        {2'd2, 4'd13, 32'h3333_000D},
        {2'd3, 4'd14, 32'h4444_000E},
        {2'd2, 4'd10, 32'h1111_000A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_set_en = 1'b1; mode_set_val = m;
        @(negedge clk); mode_set_en = 1'b0;
    endtask

    task automatic write_reg(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic enter_exc(input logic [1:0] k);
        @(negedge clk); exc_en = 1'b1; exc_kind = k;
        @(negedge clk); exc_en = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] i, output logic [31:0] d);
        @(negedge clk); rd_a_idx = i; #1; d = rd_a_data;
    endtask

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state
        #1;
        check("R4 mode", {30'd0, mode_out}, 32'd3);
        read_reg(4'd0, v);  check("R4 r0", v, 32'd0);
        read_reg(4'd15, v); check("R4 pc", v, 32'd0);
        read_reg(4'd14, v); check("R4 r14", v, 32'd0);

        // R12: write table through all modes, then read back after round trip
        for (int i = 0; i < 8; i++) begin
            set_mode(WR_TAB[i][37:36]);
            write_reg(WR_TAB[i][35:32], WR_TAB[i][31:0]);
        end
        for (int i = 7; i >= 0; i--) begin
            set_mode(WR_TAB[i][37:36]);
            read_reg(WR_TAB[i][35:32], v);
            check("R12 round trip", v, WR_TAB[i][31:0]);
        end

        // R2: FIQ bank private, low registers shared
        set_mode(2'd1);
        read_reg(4'd3, v);  check("R2 fiq r3 shared", v, 32'h1111_0003);
        read_reg(4'd10, v); check("R2 fiq r10 private", v, 32'd0);
        read_reg(4'd9, v);  check("R2 fiq r9", v, 32'h2222_0009);
        set_mode(2'd0);
        read_reg(4'd9, v);  check("R2 usr r9", v, 32'h1111_0009);

        // R3: IRQ and SVC private pairs, 8..12 shared with user
        set_mode(2'd2);
        read_reg(4'd9, v);  check("R3 irq r9 user copy", v, 32'h1111_0009);
        read_reg(4'd14, v); check("R3 irq r14 private", v, 32'd0);
        set_mode(2'd3);
        read_reg(4'd13, v); check("R3 svc r13 private", v, 32'd0);
        read_reg(4'd10, v); check("R3 svc r10 user copy", v, 32'h1111_000A);

        // R1: PC masking
        write_reg(4'd15, 32'hFFFF_FFFF);
        read_reg(4'd15, v); check("R1 pc mask", v, 32'h03FF_FFFC);

        // R8 R9: offset wraps out of the address field
        @(negedge clk); pc_offset = 32'd8; status_in = 32'hFC00_0003; #1;
        check("R8 pc+status", pc_stat_data, 32'hFC00_0007);
        check("R9 pc only", pc_only_data, 32'h0000_0004);
        @(negedge clk); pc_offset = 32'h0000_0100; status_in = 32'h0; #1;
        check("R8 pc+status no status", pc_stat_data, 32'h0000_00FC);
        check("R9 pc only plain", pc_only_data, 32'h0000_00FC);

        // R5 R6 R7: exception entry
        write_reg(4'd15, 32'h0000_1000);
        enter_exc(2'd0); #1;
        check("R5 mode irq", {30'd0, mode_out}, 32'd2);
        read_reg(4'd14, v); check("R5 irq link", v, 32'h0000_1008);
        enter_exc(2'd1); #1;
        check("R6 mode fiq", {30'd0, mode_out}, 32'd1);
        read_reg(4'd14, v); check("R6 fiq link", v, 32'h0000_1008);
        enter_exc(2'd3); #1;
        check("R7 mode svc", {30'd0, mode_out}, 32'd3);
        read_reg(4'd14, v); check("R7 svc link", v, 32'h0000_1004);
        write_reg(4'd15, 32'h03FF_FFFC);
        enter_exc(2'd2);
        read_reg(4'd14, v); check("R7 svc link wraps", v, 32'h0000_0000);
        read_reg(4'd13, v); check("R7 svc r13 kept", v, 32'd0);

        // R10: same-cycle read and write use the old mapping
        write_reg(4'd15, 32'h0000_1000);
        set_mode(2'd0);
        @(negedge clk);
        mode_set_en = 1'b1; mode_set_val = 2'd1; rd_a_idx = 4'd13;
        wr_en = 1'b1; wr_idx = 4'd12; wr_data = 32'h5555_000C; #1;
        check("R10 old mapping read", rd_a_data, 32'h1111_000D);
        @(negedge clk); mode_set_en = 1'b0; wr_en = 1'b0; #1;
        check("R10 new mapping read", rd_a_data, 32'h2222_000D);
        read_reg(4'd12, v); check("R10 fiq r12 untouched", v, 32'd0);
        set_mode(2'd0);
        read_reg(4'd12, v); check("R10 usr r12 written", v, 32'h5555_000C);

        // R11: exception beats write to same slot and a mode request
        set_mode(2'd2);
        @(negedge clk);
        exc_en = 1'b1; exc_kind = 2'd0;
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEAD_BEEF;
        mode_set_en = 1'b1; mode_set_val = 2'd0;
        @(negedge clk); exc_en = 1'b0; wr_en = 1'b0; mode_set_en = 1'b0; #1;
        check("R11 mode", {30'd0, mode_out}, 32'd2);
        read_reg(4'd14, v); check("R11 link wins", v, 32'h0000_1008);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule